// File: doc/BRIEF.md
# Programmable Two-Digit BCD Up-Counter

This block counts upward from zero toward a programmable limit and stops there. It presents the running value as two binary-coded decimal digits, tens and ones. A single mode input selects between two phases. In the set phase the count is held at zero and the limit is taken from a 7-bit binary input. In the run phase the limit is frozen and the count advances on each clock edge where the step enable is high.

Inside, a 7-bit binary count register feeds a combinational shift-and-add-3 converter, so the digits follow the register with no extra delay. A limit above 99 is reduced to 99 when it is captured. The count therefore never exceeds 99, and neither digit ever shows more than 9. When the count reaches the stored limit it holds there and does not wrap.

Top module: `bcdLimitCounter`

## Requirements
- R1: While the active-low reset `rstN` is low, both digits read 0 and the stored limit is 0.
- R2: In set mode (`runMode` = 0), the count is 0 after every rising edge, and `stepEn` has no effect.
- R3: The limit is captured from `limitIn` on each rising edge while `runMode` is 0. Changes to `limitIn` while `runMode` is 1 have no effect on where counting stops.
- R4: With `runMode` = 1 and `stepEn` = 1, the count rises by exactly one per rising edge while it is below the limit. With `stepEn` = 0, the count holds.
- R5: Once the count equals the stored limit, it holds at that value and never wraps to 0 or rises past the limit.
- R6: A captured `limitIn` value above 99 is stored as 99, so counting stops at 99.
- R7: With a stored limit of 0, the count stays 0 in run mode whatever `stepEn` does.
- R8: `tensDigit` equals count / 10 and `onesDigit` equals count mod 10. Both are 4-bit unsigned values that change in the same cycle as the count register.
- R9: When `runMode` returns to 0 from any count, the count is 0 after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| runMode | input | 1 | 0 = set mode (clear count, load limit), 1 = run mode |
| stepEn | input | 1 | Count enable in run mode |
| limitIn | input | 7 | Binary count limit, sampled in set mode |
| tensDigit | output | 4 | BCD tens digit of the count |
| onesDigit | output | 4 | BCD ones digit of the count |

## Verification
A wrong count register shows at the digits in the cycle right after the faulty edge, because the converter adds no latency. The sweep through every value from 0 to 99 exposes a converter fault at the first affected value. A limit register that keeps sampling during run mode, or that skips the clamp, shows only when the count reaches its stopping point. For that reason the tests step past the expected stop and read the held value. A missing clear shows as a nonzero digit one edge after the mode returns to set.

// File: rtl/bcdCntPkg.sv
package bcdCntPkg;
  typedef struct packed {
    logic clear;
    logic load;
    logic incr;
  } ctlStrobeT;
endpackage

// File: rtl/binToBcd.sv
module binToBcd #(
  parameter int IN_W   = 7,
  parameter int DIGITS = 2
) (
  input  logic [IN_W-1:0]     binIn,
  output logic [DIGITS*4-1:0] bcdOut
);
  localparam int BCD_W = DIGITS * 4;

  logic [BCD_W-1:0] acc;

  // shift-and-add-3: before each shift, any digit of 5 or more gets 3 added
  always_comb begin
    acc = '0;
    for (int i = IN_W - 1; i >= 0; i--) begin
      for (int d = 0; d < DIGITS; d++) begin
        if (acc[d*4 +: 4] >= 4'd5) acc[d*4 +: 4] = acc[d*4 +: 4] + 4'd3;
      end
      acc = {acc[BCD_W-2:0], binIn[i]};
    end
    bcdOut = acc;
  end
endmodule

// File: rtl/cntControl.sv
module cntControl
  import bcdCntPkg::*;
(
  input  logic      runMode,
  input  logic      stepEn,
  input  logic      atLimit,
  output ctlStrobeT ctl
);
  always_comb begin
    ctl.clear = !runMode;
    ctl.load  = !runMode;
    ctl.incr  = runMode && stepEn && !atLimit;
  end
endmodule

// File: rtl/cntDatapath.sv
module cntDatapath
  import bcdCntPkg::*;
#(
  parameter int CNT_W   = 7,
  parameter int MAX_VAL = 99,
  parameter int DIGITS  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobeT           ctl,
  input  logic [CNT_W-1:0]    limitIn,
  output logic                atLimit,
  output logic [DIGITS*4-1:0] digitsOut
);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_VAL);

  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] limitQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          limitQ <= '0;
    else if (ctl.load)  limitQ <= (limitIn > MAX_V) ? MAX_V : limitIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          countQ <= '0;
    else if (ctl.clear) countQ <= '0;
    else if (ctl.incr)  countQ <= countQ + CNT_W'(1);
  end

  assign atLimit = (countQ >= limitQ);

  binToBcd #(.IN_W(CNT_W), .DIGITS(DIGITS)) i_conv (
    .binIn (countQ),
    .bcdOut(digitsOut)
  );

  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> countQ == '0);
  a_r3_limit_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(limitQ));
  a_r4_step_one: assert property (@(posedge clk) disable iff (!rstN)
    ctl.incr |=> countQ == $past(countQ) + CNT_W'(1));
  a_r5_no_pass_limit: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= limitQ);
  a_r6_limit_cap: assert property (@(posedge clk) disable iff (!rstN)
    limitQ <= MAX_V);

  for (genvar d = 0; d < DIGITS; d++) begin : g_digitChk
    a_r8_digit_range: assert property (@(posedge clk) disable iff (!rstN)
      digitsOut[d*4 +: 4] <= 4'd9);
  end
endmodule

// File: rtl/bcdLimitCounter.sv
module bcdLimitCounter
  import bcdCntPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       runMode,
  input  logic       stepEn,
  input  logic [6:0] limitIn,
  output logic [3:0] tensDigit,
  output logic [3:0] onesDigit
);
  localparam int CNT_W   = 7;
  localparam int MAX_VAL = 99;
  localparam int DIGITS  = 2;

  ctlStrobeT             ctl;
  logic                  atLimit;
  logic [DIGITS*4-1:0]   digits;

  cntControl i_ctl (
    .runMode(runMode),
    .stepEn (stepEn),
    .atLimit(atLimit),
    .ctl    (ctl)
  );

  cntDatapath #(.CNT_W(CNT_W), .MAX_VAL(MAX_VAL), .DIGITS(DIGITS)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .limitIn  (limitIn),
    .atLimit  (atLimit),
    .digitsOut(digits)
  );

  assign onesDigit = digits[3:0];
  assign tensDigit = digits[7:4];

  a_r9_drop_clears: assert property (@(posedge clk) disable iff (!rstN)
    !runMode |=> (tensDigit == 4'd0 && onesDigit == 4'd0));
endmodule

// File: tb/test_bcdLimitCounter.sv
module test_bcdLimitCounter;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runMode = 1'b0;
  logic stepEn = 1'b0;
  logic [6:0] limitIn = '0;
  logic [3:0] tensDigit, onesDigit;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  bcdLimitCounter i_bcdLimitCounter (
    .clk(clk), .rstN(rstN), .runMode(runMode), .stepEn(stepEn),
    .limitIn(limitIn), .tensDigit(tensDigit), .onesDigit(onesDigit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic checkVal(input int exp, input string req);
    int gotV;
    checks++;
    gotV = tensDigit * 10 + onesDigit;
    if (tensDigit != 4'(exp / 10) || onesDigit != 4'(exp % 10)) begin
      errors++;
      $display("FAIL %s: got tens=%0d ones=%0d (%0d), expected %0d",
               req, tensDigit, onesDigit, gotV, exp);
    end
  endtask

  task automatic loadLimit(input int v);
    runMode = 1'b0;
    stepEn  = 1'b0;
    limitIn = 7'(v);
    tick();
    checkVal(0, "R2");
  endtask

  task automatic testReset();
    rstN = 1'b0;
    tick(2);
    checkVal(0, "R1");
    rstN = 1'b1;
    runMode = 1'b1;
    stepEn  = 1'b1;
    tick(3);
    checkVal(0, "R1 limit zero after reset");
    runMode = 1'b0;
    tick();
  endtask

  task automatic testCountAndHold();
    loadLimit(25);
    runMode = 1'b1;
    stepEn  = 1'b1;
    tick(10);
    checkVal(10, "R4");
    stepEn = 1'b0;
    tick(4);
    checkVal(10, "R4 hold");
    stepEn = 1'b1;
    tick(20);
    checkVal(25, "R5");
    tick(5);
    checkVal(25, "R5 no wrap");
  endtask

  task automatic testFrozenLimit();
    loadLimit(40);
    runMode = 1'b1;
    stepEn  = 1'b1;
    tick(5);
    checkVal(5, "R4");
    limitIn = 7'd10;
    tick(50);
    checkVal(40, "R3");
  endtask

  task automatic testDropAndSet();
    runMode = 1'b0;
    tick();
    checkVal(0, "R9");
    stepEn = 1'b1;
    tick(6);
    checkVal(0, "R2 stepEn ignored");
  endtask

  task automatic testClamp();
    loadLimit(127);
    runMode = 1'b1;
    stepEn  = 1'b1;
    tick(120);
    checkVal(99, "R6");
    runMode = 1'b0;
    tick();
    checkVal(0, "R9 from 99");
  endtask

  task automatic testZeroLimit();
    loadLimit(0);
    runMode = 1'b1;
    stepEn  = 1'b1;
    tick(5);
    checkVal(0, "R7");
  endtask

  task automatic testSweep();
    loadLimit(99);
    runMode = 1'b1;
    stepEn  = 1'b1;
    for (int v = 1; v <= 99; v++) begin
      tick();
      checkVal(v, "R8");
    end
    tick();
    checkVal(99, "R5 at 99");
    runMode = 1'b0;
    tick();
  endtask

  initial begin
    testReset();
    testCountAndHold();
    testFrozenLimit();
    testDropAndSet();
    testClamp();
    testZeroLimit();
    testSweep();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule